// File: doc/BRIEF.md
# Escape Run Byte Decoder

This block sits between a compressed image store (ROM or flash) and the loader that feeds a programmable device's configuration port. The image comes in as a byte stream. The two byte values made only of zeros and only of ones are escapes. Each escape byte is followed by a count byte, and the pair expands into that many copies of the escape value. Every other byte is a literal and passes through once, unchanged. Runs always cover whole bytes. Even a single all-zero or all-one byte must be encoded as a pair with a count of one, so the stream never needs a separate marker byte.

Both sides use valid/ready handshaking. An end-of-stream flag travels with the input bytes and comes out on the last byte that the final token produces. The output is registered. While a run is being expanded, the input is stalled, and one byte leaves per cycle whenever the sink is ready. In the final cycle of a run, the next input byte is already taken in, so runs follow each other with no idle cycle. Two malformed inputs set sticky error flags that only reset clears: a count of zero, and a stream that ends right after an escape byte.

Top module: `esc_run_decoder`

## Requirements
- R1: A byte other than 0x00 and 0xFF is output exactly once with its value unchanged, in input order.
- R2: An input byte 0x00 followed by a count byte N (1..255) produces exactly N output bytes of 0x00; for example 0x00 0x04 gives four bytes.
- R3: An input byte 0xFF followed by a count byte N produces exactly N output bytes of 0xFF. A count of 1 produces exactly one byte for either escape value.
- R4: The largest count, 255, produces 255 bytes, including when the output is stalled at irregular times.
- R5: A count byte of 0 produces no output and sets err_zero_count. The flag stays high until reset, and later tokens still decode.
- R6: An escape byte that carries in_last (no count byte follows) produces no output and sets err_truncated. The flag stays high until reset.
- R7: While a run still has more than one byte left to emit, in_ready is low. When out_ready is high, one run byte is emitted per cycle.
- R8: When the input is always valid and out_ready stays high, two consecutive escape pairs whose counts are both at least 2 come out with no idle output cycle between the two runs.
- R9: out_last is high only on the final output byte of the token whose last input byte carried in_last.
- R10: While out_valid is high and out_ready is low, out_data and out_last hold their values and in_ready is low.
- R11: After reset, out_valid is low, in_ready is high, and both error flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Compressed byte available |
| in_ready | output | 1 | Decoder accepts the byte this cycle |
| in_data | input | DATA_W | Compressed byte |
| in_last | input | 1 | Byte is the final one of the image |
| out_valid | output | 1 | Decoded byte available |
| out_ready | input | 1 | Sink accepts the decoded byte |
| out_data | output | DATA_W | Decoded byte |
| out_last | output | 1 | Final decoded byte of the image |
| err_zero_count | output | 1 | Sticky: a count byte of zero was seen |
| err_truncated | output | 1 | Sticky: the stream ended after an escape byte |

## Verification
The assertions check on every cycle that a stalled output holds still and that no input is taken while the output is stalled. They also check that each error flag stays high once it is set. The expansion counts, the placement of the end flag, the absence of idle cycles between runs, and the silence after a zero count can only be shown by the bench's scenarios. The bench compares every decoded byte against a queue built from the encoded tokens, both with a free-flowing sink and with a sink that stalls at irregular times.

// File: rtl/esc_run_pkg.sv
package esc_run_pkg;

    // Decoder phases
    typedef enum logic [1:0] {
        ST_BYTE  = 2'd0,   // expecting a literal or an escape byte
        ST_COUNT = 2'd1,   // expecting the count byte after an escape
        ST_RUN   = 2'd2,   // emitting the remaining bytes of a run
        ST_PEND  = 2'd3    // a literal taken during a run's last cycle waits
    } run_state_e;

endpackage

// File: rtl/esc_classify.sv
module esc_classify #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] byte_i,
    output logic              is_esc_o,
    output logic              is_zero_o
);

    localparam logic [DATA_W-1:0] ALL_ZERO = '0;
    localparam logic [DATA_W-1:0] ALL_ONE  = '1;

    always_comb begin
        is_zero_o = (byte_i == ALL_ZERO);
        is_esc_o  = is_zero_o || (byte_i == ALL_ONE);
    end

endmodule

// File: rtl/esc_run_fsm.sv
module esc_run_fsm
    import esc_run_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    input  logic              in_is_esc,
    input  logic              in_is_zero,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              err_zero_count,
    output logic              err_truncated
);

    localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

    typedef struct packed {
        run_state_e        st;
        logic [DATA_W-1:0] rem;       // run bytes still to emit
        logic [DATA_W-1:0] val;       // escape value or pending literal
        logic              tail;      // token ends the stream
        logic              ov;
        logic [DATA_W-1:0] od;
        logic              ol;
        logic              ez;
        logic              et;
    } regs_t;

    regs_t q, d;
    logic  out_free;
    logic  take;

    always_comb begin
        d        = q;
        out_free = !q.ov || out_ready;
        if (out_free) begin
            d.ov = 1'b0;
        end

        unique case (q.st)
            ST_BYTE, ST_COUNT: in_ready = out_free;
            ST_RUN:            in_ready = out_free && (q.rem == ONE);
            default:           in_ready = 1'b0;
        endcase
        take = in_valid && in_ready;

        unique case (q.st)
            ST_BYTE: begin
                if (take) begin
                    if (in_is_esc) begin
                        if (in_last) begin
                            d.et = 1'b1;
                        end else begin
                            d.val = in_data;
                            d.st  = ST_COUNT;
                        end
                    end else begin
                        d.ov = 1'b1;
                        d.od = in_data;
                        d.ol = in_last;
                    end
                end
            end
            ST_COUNT: begin
                if (take) begin
                    if (in_is_zero) begin
                        d.ez = 1'b1;
                        d.st = ST_BYTE;
                    end else begin
                        d.ov   = 1'b1;
                        d.od   = q.val;
                        d.ol   = in_last && (in_data == ONE);
                        d.rem  = in_data - ONE;
                        d.tail = in_last;
                        d.st   = (in_data == ONE) ? ST_BYTE : ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (out_free) begin
                    d.ov  = 1'b1;
                    d.od  = q.val;
                    d.ol  = q.tail && (q.rem == ONE);
                    d.rem = q.rem - ONE;
                    if (q.rem == ONE) begin
                        d.st = ST_BYTE;
                    end
                end
                if (take) begin
                    if (in_is_esc) begin
                        if (in_last) begin
                            d.et = 1'b1;
                        end else begin
                            d.val = in_data;
                            d.st  = ST_COUNT;
                        end
                    end else begin
                        d.val  = in_data;
                        d.tail = in_last;
                        d.st   = ST_PEND;
                    end
                end
            end
            default: begin
                if (out_free) begin
                    d.ov = 1'b1;
                    d.od = q.val;
                    d.ol = q.tail;
                    d.st = ST_BYTE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_BYTE, rem: '0, val: '0, tail: 1'b0, ov: 1'b0,
                   od: '0, ol: 1'b0, ez: 1'b0, et: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign out_valid      = q.ov;
    assign out_data       = q.od;
    assign out_last       = q.ol;
    assign err_zero_count = q.ez;
    assign err_truncated  = q.et;

endmodule

// File: rtl/esc_run_decoder.sv
module esc_run_decoder #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              err_zero_count,
    output logic              err_truncated
);

    logic is_esc;
    logic is_zero;

    esc_classify #(.DATA_W(DATA_W)) classify_i (
        .byte_i    (in_data),
        .is_esc_o  (is_esc),
        .is_zero_o (is_zero)
    );

    esc_run_fsm #(.DATA_W(DATA_W)) fsm_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_data        (in_data),
        .in_last        (in_last),
        .in_is_esc      (is_esc),
        .in_is_zero     (is_zero),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .out_data       (out_data),
        .out_last       (out_last),
        .err_zero_count (err_zero_count),
        .err_truncated  (err_truncated)
    );

endmodule

// File: rtl/esc_run_decoder_chk.sv
module esc_run_decoder_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last,
    input logic              err_zero_count,
    input logic              err_truncated
);

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

    // R10
    no_take_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready);

    // R5
    zero_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_zero_count |=> err_zero_count);

    // R6
    trunc_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_truncated |=> err_truncated);

endmodule

bind esc_run_decoder esc_run_decoder_chk #(.DATA_W(DATA_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_ready       (in_ready),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .out_data       (out_data),
    .out_last       (out_last),
    .err_zero_count (err_zero_count),
    .err_truncated  (err_truncated)
);

// File: tb/esc_run_decoder_tb_top.sv
module esc_run_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_data;
    logic       out_last;
    logic       err_zero_count;
    logic       err_truncated;

    always #5 clk = ~clk;

    esc_run_decoder #(.DATA_W(8)) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_ready       (in_ready),
        .in_data        (in_data),
        .in_last        (in_last),
        .out_valid      (out_valid),
        .out_ready      (out_ready),
        .out_data       (out_data),
        .out_last       (out_last),
        .err_zero_count (err_zero_count),
        .err_truncated  (err_truncated)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;
    logic [8:0] exp_q[$];
    string tag_q[$];

    bit         bp_mode   = 1'b0;
    bit         hold_mode = 1'b0;
    logic [7:0] lfsr      = 8'hA5;
    int         streak    = 0;
    int         max_streak = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // sink ready pattern
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = hold_mode ? 1'b0 : (bp_mode ? lfsr[0] : 1'b1);
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        #2;
        if (rst_n && out_valid && out_ready) begin
            streak++;
            if (streak > max_streak) max_streak = streak;
            if (exp_q.size() == 0) begin
                check(1'b0, "unexpected output", {out_last, out_data}, 0);
            end else begin
                logic [8:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({out_last, out_data} == e, t, {out_last, out_data}, e);
            end
        end else begin
            streak = 0;
        end
    end

    task automatic send_byte(input logic [7:0] b, input bit last);
        bit acc;
        acc = 1'b0;
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        in_last  = last;
        while (!acc) begin
            #1;
            acc = in_ready;
            @(posedge clk);
            if (!acc) @(negedge clk);
        end
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic lit(input logic [7:0] b, input bit last, input string tag);
        exp_q.push_back({last, b});
        tag_q.push_back(tag);
        send_byte(b, last);
    endtask

    task automatic pair(input logic [7:0] v, input logic [7:0] cnt, input bit last,
                        input string tag);
        for (int i = 1; i <= int'(cnt); i++) begin
            exp_q.push_back({last && (i == int'(cnt)), v});
            tag_q.push_back(tag);
        end
        send_byte(v, 1'b0);
        send_byte(cnt, last);
    endtask

    task automatic drain(input string tag);
        int n;
        n = 0;
        while (exp_q.size() != 0 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        #1;
    endtask

    initial begin
        do_reset();
        // R11 reset state
        check(out_valid == 1'b0, "R11 out_valid", out_valid, 0);
        check(in_ready == 1'b1, "R11 in_ready", in_ready, 1);
        check(err_zero_count == 1'b0, "R11 err_zero_count", err_zero_count, 0);
        check(err_truncated == 1'b0, "R11 err_truncated", err_truncated, 0);

        // R1 literals
        lit(8'h12, 1'b0, "R1 literal");
        lit(8'h7E, 1'b0, "R1 literal");
        lit(8'h80, 1'b0, "R1 literal");
        lit(8'h01, 1'b0, "R1 literal");
        drain("R1 drain");

        // R2 zero run of four
        pair(8'h00, 8'd4, 1'b0, "R2 zero run");
        drain("R2 drain");

        // R3 ones runs and single-byte runs
        pair(8'hFF, 8'd6, 1'b0, "R3 ones run");
        pair(8'hFF, 8'd1, 1'b0, "R3 single ones");
        pair(8'h00, 8'd1, 1'b0, "R3 single zero");
        lit(8'hFE, 1'b0, "R3 literal after single");
        drain("R3 drain");

        // R7 input stalled during a run
        pair(8'h00, 8'd5, 1'b0, "R7 run");
        @(negedge clk); #1;
        check(in_ready == 1'b0, "R7 in_ready low in run", in_ready, 0);
        drain("R7 drain");

        // R8 back-to-back runs without gaps
        repeat (3) @(negedge clk);
        max_streak = 0;
        pair(8'h00, 8'd3, 1'b0, "R8 first run");
        pair(8'hFF, 8'd3, 1'b0, "R8 second run");
        drain("R8 drain");
        check(max_streak >= 6, "R8 gapless transfers", max_streak, 6);

        // R9 end flag on literal and on run
        lit(8'h44, 1'b1, "R9 last literal");
        pair(8'hFF, 8'd3, 1'b1, "R9 last run");
        pair(8'h00, 8'd2, 1'b0, "R9 run then last literal");
        lit(8'h55, 1'b1, "R9 pending literal last");
        drain("R9 drain");

        // R4 max count under irregular stalls, plus mixed stream
        bp_mode = 1'b1;
        pair(8'h00, 8'd255, 1'b0, "R4 max run");
        lit(8'hC3, 1'b0, "R4 literal after max");
        pair(8'hFF, 8'd9, 1'b0, "R4 ones under stall");
        pair(8'h00, 8'd2, 1'b0, "R4 short run");
        lit(8'h3C, 1'b1, "R4 closing literal");
        drain("R4 drain");
        bp_mode = 1'b0;

        // R10 hold under stall
        hold_mode = 1'b1;
        lit(8'h33, 1'b0, "R10 held literal");
        repeat (3) @(negedge clk);
        #1;
        check(out_valid && out_data == 8'h33, "R10 data held", out_data, 8'h33);
        check(in_ready == 1'b0, "R10 in_ready low when stalled", in_ready, 0);
        hold_mode = 1'b0;
        drain("R10 drain");

        // R5 zero count
        pair(8'h00, 8'd0, 1'b0, "R5 zero count");
        @(negedge clk); #1;
        check(err_zero_count == 1'b1, "R5 err_zero_count set", err_zero_count, 1);
        lit(8'h5A, 1'b0, "R5 literal after error");
        drain("R5 drain");
        check(err_zero_count == 1'b1, "R5 err_zero_count sticky", err_zero_count, 1);

        // R11 errors cleared by reset
        do_reset();
        check(err_zero_count == 1'b0, "R11 err cleared", err_zero_count, 0);

        // R6 truncated stream
        send_byte(8'hFF, 1'b1);
        @(negedge clk); #1;
        check(err_truncated == 1'b1, "R6 err_truncated set", err_truncated, 1);
        check(err_zero_count == 1'b0, "R6 other flag clear", err_zero_count, 0);
        lit(8'h21, 1'b1, "R6 literal after truncation");
        drain("R6 drain");
        check(err_truncated == 1'b1, "R6 err_truncated sticky", err_truncated, 1);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule